// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two fault indications into one clean system reset. The first is a supply-low flag. It arrives already synchronous and comes from an external comparator. The second is a raw, active-low manual reset line. A push-button may drive that line directly, so it can bounce and is asynchronous to the clock. The block synchronizes and filters the manual line. It asserts reset while either cause is present. Once both causes are gone, it keeps reset asserted for a further hold interval, counted in clock cycles.

Both polarities of the reset are driven, so active-high and active-low consumers can connect without extra logic. When the block's own asynchronous reset is applied, the outputs come up asserted, and the hold interval runs before the first release. A watchdog timeout is not a reset source here. To make it one, route the watchdog output onto the manual reset line.

No data stream flows through the block, so it has no valid/ready interface. Every pin is a plain control level.

Top module: `sup_reset_gen`

## Requirements
- R1: While `supply_low_i` is 1, `rst_o` is 1 in the same cycle, with no register in between.
- R2: A 0 on `manual_rst_ni` held for at least DEBOUNCE_CYCLES cycles asserts `rst_o` after exactly SYNC_STAGES + DEBOUNCE_CYCLES rising clock edges.
- R3: A level on `manual_rst_ni` that lasts fewer than DEBOUNCE_CYCLES cycles (a bounce or glitch) has no effect on `rst_o`.
- R4: After the last cause clears, `rst_o` stays 1 for exactly HOLD_CYCLES rising edges and then falls to 0.
- R5: Releasing `manual_rst_ni` to 1 deasserts `rst_o` after SYNC_STAGES + DEBOUNCE_CYCLES + HOLD_CYCLES rising edges, provided the supply is good.
- R6: If a cause returns during the hold interval, the hold count restarts from zero once all causes clear again.
- R7: `rst_no` is always the exact inverse of `rst_o`.
- R8: While `arst_ni` is 0, `rst_o` is 1. With no cause present, `rst_o` falls HOLD_CYCLES rising edges after `arst_ni` is released.
- R9: With no cause present and the hold interval complete, `rst_o` stays 0. There is no other reset source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| arst_ni | input | 1 | Asynchronous power-on reset, active low |
| supply_low_i | input | 1 | Synchronous supply-low flag, 1 = supply below threshold |
| manual_rst_ni | input | 1 | Raw manual reset request, active low, may bounce |
| rst_no | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high |

## Verification
On every cycle, the assertions check three things: the supply-low flag forces reset immediately, the two outputs stay complementary, and the reset falls only after exactly HOLD_CYCLES quiet cycles following the filtered causes. The filter's own behaviour can only be shown by the bench's scenarios. These are the exact press and release latencies through the synchronizer and the stability counter, and the rejection of bounces shorter than the filter window. Restart of the hold when a cause returns mid-interval, and the power-on sequence, are shown both ways.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  typedef enum logic [1:0] {
    HS_CAUSE = 2'd0,
    HS_HOLD  = 2'd1,
    HS_RUN   = 2'd2
  } hold_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    int unsigned w;
    w = $clog2(limit + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) chain_q[0] <= RESET_VAL;
        else          chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) chain_q[g] <= RESET_VAL;
        else          chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsg_debounce.sv
module rsg_debounce #(
  parameter int unsigned CYCLES    = 16,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic level_i,
  output logic level_o
);
  import rsg_pkg::*;

  localparam int unsigned CW = cnt_width(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          level_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      level_q <= RESET_VAL;
      run_q   <= '0;
    end else if (level_i == level_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      level_q <= level_i;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/rsg_hold_timer.sv
module rsg_hold_timer #(
  parameter int unsigned CYCLES = 64
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic cause_i,
  output logic hold_o
);
  import rsg_pkg::*;

  localparam int unsigned CW = cnt_width(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  hold_state_e   state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      state_q <= HS_HOLD;
      cnt_q   <= '0;
    end else if (cause_i) begin
      state_q <= HS_CAUSE;
      cnt_q   <= '0;
    end else if (state_q != HS_RUN) begin
      if (cnt_q == LAST) begin
        state_q <= HS_RUN;
        cnt_q   <= '0;
      end else begin
        state_q <= HS_HOLD;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = (state_q != HS_RUN);
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEBOUNCE_CYCLES = 16,
  parameter int unsigned HOLD_CYCLES     = 64
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic supply_low_i,
  input  logic manual_rst_ni,
  output logic rst_no,
  output logic rst_o
);
  logic mr_sync;
  logic mr_clean;
  logic cause;
  logic hold;

  rsg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .async_i (manual_rst_ni),
    .sync_o  (mr_sync)
  );

  rsg_debounce #(.CYCLES(DEBOUNCE_CYCLES), .RESET_VAL(1'b1)) u_deb (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .level_i (mr_sync),
    .level_o (mr_clean)
  );

  assign cause = supply_low_i | ~mr_clean;

  rsg_hold_timer #(.CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .cause_i (cause),
    .hold_o  (hold)
  );

  assign rst_o  = cause | hold;
  assign rst_no = ~rst_o;
endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
  parameter int unsigned HOLD_CYCLES = 64
) (
  input logic clk_i,
  input logic arst_ni,
  input logic supply_low_i,
  input logic mr_clean_i,
  input logic rst_o,
  input logic rst_no
);
  localparam int unsigned QW = $clog2(HOLD_CYCLES + 1) + 1;
  localparam logic [QW-1:0] QMAX = QW'(HOLD_CYCLES);

  logic          cause_seen;
  logic [QW-1:0] quiet_q;

  assign cause_seen = supply_low_i | ~mr_clean_i;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)        quiet_q <= '0;
    else if (cause_seen) quiet_q <= '0;
    else if (quiet_q < QMAX) quiet_q <= quiet_q + 1'b1;
  end

  // R1
  supply_forces_rst_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    supply_low_i |-> rst_o);

  // R7
  polarity_pair_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rst_no != rst_o);

  // R4
  hold_not_short_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (quiet_q < QMAX) |-> rst_o);

  // R9
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (!cause_seen && quiet_q == QMAX) |-> !rst_o);

  // R6
  release_after_full_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (!rst_o && $past(rst_o)) |-> (quiet_q == QMAX));
endmodule

bind sup_reset_gen sup_reset_gen_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .arst_ni      (arst_ni),
  .supply_low_i (supply_low_i),
  .mr_clean_i   (mr_clean),
  .rst_o        (rst_o),
  .rst_no       (rst_no)
);

// File: tb/tb_sup_reset_gen.sv
module tb_sup_reset_gen;
  localparam int unsigned S = 2;
  localparam int unsigned D = 8;
  localparam int unsigned H = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic arst_n = 1'b0;
  logic sup    = 1'b0;
  logic mr_n   = 1'b1;
  logic rst_o, rst_no;

  sup_reset_gen #(.SYNC_STAGES(S), .DEBOUNCE_CYCLES(D), .HOLD_CYCLES(H)) dut (
    .clk_i(clk), .arst_ni(arst_n), .supply_low_i(sup), .manual_rst_ni(mr_n),
    .rst_no(rst_no), .rst_o(rst_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench reference built from the requirements: S-stage delay, D-cycle stability, H-cycle hold.
  logic [S-1:0] m_sh = '1;
  logic         m_deb = 1'b1;
  int           m_dcnt = 0;
  logic         m_hrst = 1'b1;
  int           m_hcnt = 0;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_sh = '1; m_deb = 1'b1; m_dcnt = 0; m_hrst = 1'b1; m_hcnt = 0;
    end else begin
      if (sup || !m_deb) begin
        m_hrst = 1'b1; m_hcnt = 0;
      end else if (m_hrst) begin
        if (m_hcnt == H - 1) begin m_hrst = 1'b0; m_hcnt = 0; end
        else m_hcnt++;
      end
      if (m_sh[S-1] == m_deb) m_dcnt = 0;
      else if (m_dcnt == D - 1) begin m_deb = m_sh[S-1]; m_dcnt = 0; end
      else m_dcnt++;
      m_sh = {m_sh[S-2:0], mr_n};
    end
  end

  function automatic logic exp_rst();
    return m_hrst | sup | ~m_deb;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("R4 model", rst_o, exp_rst());
    check("R7", rst_no, ~rst_o);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int run;
    #1;
    check("R8 power-on", rst_o, 1'b1);
    check("R7 power-on", rst_no, 1'b0);
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (H - 1) step();
    check("R8 still held", rst_o, 1'b1);
    step();
    check("R8 released", rst_o, 1'b0);

    // R1 immediate assertion, then R4 exact hold
    sup = 1'b1; #1;
    check("R1", rst_o, 1'b1);
    repeat (4) step();
    sup = 1'b0;
    repeat (H - 1) step();
    check("R4 held", rst_o, 1'b1);
    step();
    check("R4 released", rst_o, 1'b0);

    // R2 press latency, R5 release latency
    mr_n = 1'b0;
    repeat (S + D - 1) step();
    check("R2 not yet", rst_o, 1'b0);
    step();
    check("R2 asserted", rst_o, 1'b1);
    repeat (5) step();
    mr_n = 1'b1;
    repeat (S + D + H - 1) step();
    check("R5 held", rst_o, 1'b1);
    step();
    check("R5 released", rst_o, 1'b0);

    // R3 short pulse of D-1 cycles ignored
    mr_n = 1'b0;
    repeat (D - 1) step();
    mr_n = 1'b1;
    for (int i = 0; i < int'(S + D + H); i++) begin
      step();
      check("R3 short pulse", rst_o, 1'b0);
    end
    // R3 bounce train
    for (int i = 0; i < 40; i++) begin
      mr_n = ~mr_n;
      step();
      check("R3 bounce", rst_o, 1'b0);
    end
    mr_n = 1'b1;
    repeat (S + D) step();

    // R6 cause returns mid-hold
    sup = 1'b1; step();
    sup = 1'b0;
    repeat (H / 2) step();
    sup = 1'b1; step();
    sup = 1'b0;
    repeat (H - 1) step();
    check("R6 restarted hold", rst_o, 1'b1);
    step();
    check("R6 released", rst_o, 1'b0);

    // R9 idle
    for (int i = 0; i < int'(3 * H); i++) begin
      step();
      check("R9 idle", rst_o, 1'b0);
    end

    // Random phase: fixed seed, run-length driven manual line, rare supply dips
    void'($urandom(32'h5EED_0042));
    run = 0;
    for (int i = 0; i < 4000; i++) begin
      if (run == 0) begin
        mr_n = ($urandom_range(0, 3) == 0) ? ~mr_n : mr_n;
        run = $urandom_range(1, 3 * D);
      end else run--;
      if ($urandom_range(0, 99) < 3) sup = ~sup;
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule